// File: doc/BRIEF.md
# Passive SPI Bus Monitor

This block listens to an SPI bus without ever driving it. It runs on a fast system clock and treats the four bus lines (serial clock, chip select, controller-to-peripheral data and peripheral-to-controller data) as ordinary asynchronous inputs. It re-times them, finds the serial-clock edges that carry data for the configured clock polarity and phase, and shifts both data lines into separate accumulators on the same edge. When the configured number of bits has arrived, it presents both words together for one cycle.

Apart from data capture, the monitor reports every change of the chip-select level as a one-cycle event that carries the old and new levels. It marks any word whose first bit arrived while chip select was inactive. It also keeps a saturating count of completed words. A debug or trace subsystem would use it to log bus traffic next to other on-chip events.

Configuration inputs (clock polarity, clock phase, bit order, chip-select polarity and word length) are expected to change only while the monitor is in reset.

Top module: `spi_bus_sniffer`

## Requirements
- R1: Data is sampled on the rising serial-clock edge when polarity equals phase (mode 0 = {0,0}, mode 3 = {1,1}). It is sampled on the falling edge in modes 1 and 2. In reset, the clock history is preset to the idle level given by the polarity input (0 = idle low, 1 = idle high).
- R2: On every sampling edge, one bit from each data line is captured into two independent accumulators. The two words are presented together.
- R3: With `cfg_lsb_first` = 0, the first bit of a word ends up in bit position length-1 of the output word. With `cfg_lsb_first` = 1, it ends up in bit 0. Output bits at and above the word length read 0.
- R4: The word length is taken from `cfg_word_len`. A value of 0 or a value above MAX_BITS (default 32) selects MAX_BITS.
- R5: With `cfg_cs_active_high` = 0, chip select is active when the line is 0. With `cfg_cs_active_high` = 1, it is active when the line is 1.
- R6: Every change of the re-timed chip-select level produces a one-cycle `cs_evt` pulse. `cs_evt_prev` carries the old level and `cs_evt_new` carries the new level. This happens whether or not the serial clock moves.
- R7: A word whose first bit is sampled while chip select is inactive is reported with `word_warn` = 1. Bits sampled while chip select is inactive are still captured.
- R8: The warning applies only to the word in which it was set. The next word starts with the warning clear.
- R9: `word_vld` is a one-cycle pulse. `word_mosi`, `word_miso` and `word_warn` hold their values until the next word completes.
- R10: `word_count` increments with each completed word, saturates at its maximum value (CNT_W bits), and is cleared only by reset.
- R11: After reset, all outputs are 0.
- R12: A sampling edge (or chip-select change) applied to the inputs appears at the outputs after three rising system-clock edges: two synchronizer stages plus one output register. The serial clock must toggle no faster than a quarter of the system clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Clock polarity: idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_lsb_first | input | 1 | 1 = first bit goes to bit 0 |
| cfg_cs_active_high | input | 1 | 1 = chip select is active high |
| cfg_word_len | input | LEN_W | Bits per word (0 or above MAX_BITS = MAX_BITS) |
| spi_sck | input | 1 | Bus serial clock (observed) |
| spi_cs | input | 1 | Bus chip select (observed) |
| spi_mosi | input | 1 | Controller-to-peripheral data (observed) |
| spi_miso | input | 1 | Peripheral-to-controller data (observed) |
| cs_evt | output | 1 | Chip-select level changed |
| cs_evt_prev | output | 1 | Level before the change |
| cs_evt_new | output | 1 | Level after the change |
| word_vld | output | 1 | Word pair complete (one cycle) |
| word_mosi | output | MAX_BITS | Captured controller-to-peripheral word |
| word_miso | output | MAX_BITS | Captured peripheral-to-controller word |
| word_warn | output | 1 | Word began while chip select was inactive |
| word_count | output | CNT_W | Saturating count of completed words |

## Verification
Both the word pulse and the chip-select event appear after the third rising clock edge that follows the input change. That is two synchronizer stages and then one output register. The latency checks drive the input at a falling edge and sample at the falling edges after the second and third rising edges, which pins the pulse to exactly one cycle. For the table-driven vectors, a falling-edge monitor records each pulse. The bench compares the recorded values several cycles after the last serial edge, which also confirms that the data holds after the pulse.

// File: rtl/sniff_pkg.sv
package sniff_pkg;

    typedef enum logic [1:0] {
        MODE0 = 2'b00,
        MODE1 = 2'b01,
        MODE2 = 2'b10,
        MODE3 = 2'b11
    } spi_mode_e;

    // Modes whose polarity equals their phase capture on the rising edge.
    function automatic logic samples_on_rise(input spi_mode_e m);
        return (m == MODE0) || (m == MODE3);
    endfunction

endpackage

// File: rtl/sniff_sync.sv
module sniff_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.s1 <= rst_val;
            st_q.s2 <= rst_val;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/sniff_edge.sv
module sniff_edge
    import sniff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_cpol,
    input  logic cfg_cpha,
    input  logic cfg_cs_active_high,
    input  logic sck_s,
    input  logic cs_s,
    output logic bit_strobe,
    output logic cs_inactive,
    output logic cs_evt,
    output logic cs_evt_prev,
    output logic cs_evt_new
);
    typedef struct packed {
        logic sck_prev;
        logic cs_prev;
        logic evt;
        logic evt_prev;
        logic evt_new;
    } edge_t;

    edge_t st_d, st_q;
    spi_mode_e mode;
    logic      rise_mode;

    assign mode      = spi_mode_e'({cfg_cpol, cfg_cpha});
    assign rise_mode = samples_on_rise(mode);

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        st_d.cs_prev  = cs_s;
        st_d.evt      = (cs_s != st_q.cs_prev);
        st_d.evt_prev = st_q.cs_prev;
        st_d.evt_new  = cs_s;
        if (cs_s == st_q.cs_prev) begin
            st_d.evt_prev = st_q.evt_prev;
            st_d.evt_new  = st_q.evt_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sck_prev <= cfg_cpol;
            st_q.cs_prev  <= ~cfg_cs_active_high;
            st_q.evt      <= 1'b0;
            st_q.evt_prev <= 1'b0;
            st_q.evt_new  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_strobe  = (sck_s != st_q.sck_prev) && (sck_s == rise_mode);
    assign cs_inactive = (cs_s != cfg_cs_active_high);
    assign cs_evt      = st_q.evt;
    assign cs_evt_prev = st_q.evt_prev;
    assign cs_evt_new  = st_q.evt_new;

    // R6: an event always reports two different levels
    p_evt_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_evt |-> (cs_evt_prev != cs_evt_new));
    // R1: strobe only in the cycle the synchronized clock differs from last cycle
    p_strobe_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> !bit_strobe);
endmodule

// File: rtl/sniff_capture.sv
module sniff_capture #(
    parameter int MAX_BITS = 32,
    parameter int CNT_W    = 32,
    localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_lsb_first,
    input  logic [LEN_W-1:0]    eff_len,
    input  logic                bit_strobe,
    input  logic                cs_inactive,
    input  logic                mosi_s,
    input  logic                miso_s,
    output logic                word_vld,
    output logic [MAX_BITS-1:0] word_mosi,
    output logic [MAX_BITS-1:0] word_miso,
    output logic                word_warn,
    output logic [CNT_W-1:0]    word_count
);
    typedef struct packed {
        logic [LEN_W-1:0]    bits;
        logic [MAX_BITS-1:0] acc_mo;
        logic [MAX_BITS-1:0] acc_mi;
        logic                warn;
        logic                vld;
        logic [MAX_BITS-1:0] out_mo;
        logic [MAX_BITS-1:0] out_mi;
        logic                out_warn;
        logic [CNT_W-1:0]    cnt;
    } cap_t;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cap_t st_d, st_q;
    logic [LEN_W-1:0]    pos;
    logic [LEN_W-1:0]    bits_inc;
    logic [MAX_BITS-1:0] mo_next, mi_next;
    logic                warn_next;

    always_comb begin
        bits_inc  = st_q.bits + LEN_W'(1);
        pos       = cfg_lsb_first ? st_q.bits : (eff_len - LEN_W'(1) - st_q.bits);
        mo_next   = st_q.acc_mo | (MAX_BITS'(mosi_s) << pos);
        mi_next   = st_q.acc_mi | (MAX_BITS'(miso_s) << pos);
        warn_next = (st_q.bits == '0) ? cs_inactive : st_q.warn;

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (bit_strobe) begin
            if (bits_inc == eff_len) begin
                st_d.out_mo   = mo_next;
                st_d.out_mi   = mi_next;
                st_d.out_warn = warn_next;
                st_d.vld      = 1'b1;
                st_d.acc_mo   = '0;
                st_d.acc_mi   = '0;
                st_d.bits     = '0;
                st_d.warn     = 1'b0;
                if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end else begin
                st_d.acc_mo = mo_next;
                st_d.acc_mi = mi_next;
                st_d.bits   = bits_inc;
                st_d.warn   = warn_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld   = st_q.vld;
    assign word_mosi  = st_q.out_mo;
    assign word_miso  = st_q.out_mi;
    assign word_warn  = st_q.out_warn;
    assign word_count = st_q.cnt;

    // R9: single-cycle pulse
    p_vld_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    // R9: captured words hold between pulses
    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> ($stable(word_mosi) && $stable(word_miso) && $stable(word_warn)));
    // R10: count moves by one per word unless saturated
    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && ($past(word_count) != CNT_MAX)) |-> (word_count == $past(word_count) + CNT_W'(1)));
    // R10: count is stable without a word
    p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(word_count));
    // R4: the bit index stays below the active length
    p_bits_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bits < eff_len);
endmodule

// File: rtl/spi_bus_sniffer.sv
module spi_bus_sniffer #(
    parameter int MAX_BITS = 32,
    parameter int CNT_W    = 32,
    localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic                cfg_lsb_first,
    input  logic                cfg_cs_active_high,
    input  logic [LEN_W-1:0]    cfg_word_len,
    input  logic                spi_sck,
    input  logic                spi_cs,
    input  logic                spi_mosi,
    input  logic                spi_miso,
    output logic                cs_evt,
    output logic                cs_evt_prev,
    output logic                cs_evt_new,
    output logic                word_vld,
    output logic [MAX_BITS-1:0] word_mosi,
    output logic [MAX_BITS-1:0] word_miso,
    output logic                word_warn,
    output logic [CNT_W-1:0]    word_count
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BITS);

    logic [3:0]       lines_s;
    logic [3:0]       lines_rst;
    logic [LEN_W-1:0] eff_len;
    logic             bit_strobe;
    logic             cs_inactive;

    assign lines_rst = {cfg_cpol, ~cfg_cs_active_high, 1'b0, 1'b0};
    assign eff_len   = ((cfg_word_len == '0) || (cfg_word_len > LEN_MAX)) ? LEN_MAX : cfg_word_len;

    sniff_sync #(.W(4)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (lines_rst),
        .din     ({spi_sck, spi_cs, spi_mosi, spi_miso}),
        .dout    (lines_s)
    );

    sniff_edge u_edge (
        .clk                (clk),
        .rst_n              (rst_n),
        .cfg_cpol           (cfg_cpol),
        .cfg_cpha           (cfg_cpha),
        .cfg_cs_active_high (cfg_cs_active_high),
        .sck_s              (lines_s[3]),
        .cs_s               (lines_s[2]),
        .bit_strobe         (bit_strobe),
        .cs_inactive        (cs_inactive),
        .cs_evt             (cs_evt),
        .cs_evt_prev        (cs_evt_prev),
        .cs_evt_new         (cs_evt_new)
    );

    sniff_capture #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_cap (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_lsb_first (cfg_lsb_first),
        .eff_len       (eff_len),
        .bit_strobe    (bit_strobe),
        .cs_inactive   (cs_inactive),
        .mosi_s        (lines_s[1]),
        .miso_s        (lines_s[0]),
        .word_vld      (word_vld),
        .word_mosi     (word_mosi),
        .word_miso     (word_miso),
        .word_warn     (word_warn),
        .word_count    (word_count)
    );

    // R11/R4: the active length is never zero
    p_len_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eff_len != '0);
endmodule

// File: tb/tb_spi_bus_sniffer.sv
module tb_spi_bus_sniffer;
    localparam int MAXB = 32;
    localparam int CW   = 3;
    localparam int H    = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst_n = 1'b0;
    logic cpol = 0, cpha = 0, lsb = 0, csh = 0;
    logic [5:0] len = 6'd8;
    logic sck = 0, cs = 1, mosi = 0, miso = 0;
    logic cs_evt, cs_evt_prev, cs_evt_new, word_vld, word_warn;
    logic [MAXB-1:0] word_mosi, word_miso;
    logic [CW-1:0] word_count;

    spi_bus_sniffer #(.MAX_BITS(MAXB), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .cfg_lsb_first(lsb), .cfg_cs_active_high(csh), .cfg_word_len(len),
        .spi_sck(sck), .spi_cs(cs), .spi_mosi(mosi), .spi_miso(miso),
        .cs_evt(cs_evt), .cs_evt_prev(cs_evt_prev), .cs_evt_new(cs_evt_new),
        .word_vld(word_vld), .word_mosi(word_mosi), .word_miso(word_miso),
        .word_warn(word_warn), .word_count(word_count));

    int n_chk = 0, n_bad = 0;
    int n_words = 0, n_evts = 0;
    logic last_prev = 0, last_new = 0;
    bit done = 0;

    always @(negedge clk) begin
        if (rst_n && word_vld) n_words++;
        if (rst_n && cs_evt) begin
            n_evts++;
            last_prev = cs_evt_prev;
            last_new  = cs_evt_new;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sck = cpol; cs = ~csh; mosi = 0; miso = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // first wire bit is wmo[n-1]
    task automatic send_word(input int n, input logic [31:0] wmo, input logic [31:0] wmi);
        for (int i = 0; i < n; i++) begin
            if (!cpha) begin
                mosi = wmo[n-1-i]; miso = wmi[n-1-i];
                repeat (H) @(negedge clk);
                sck = ~cpol;
                repeat (H) @(negedge clk);
                sck = cpol;
            end else begin
                sck = ~cpol;
                mosi = wmo[n-1-i]; miso = wmi[n-1-i];
                repeat (H) @(negedge clk);
                sck = cpol;
                repeat (H) @(negedge clk);
            end
        end
        repeat (8) @(negedge clk);
    endtask

    typedef struct packed {
        logic cpol; logic cpha; logic lsb; logic csh; logic cs_on;
        logic [5:0] len; logic [5:0] nbits;
        logic [31:0] tx_mo; logic [31:0] tx_mi;
        logic [31:0] ex_mo; logic [31:0] ex_mi;
        logic ex_warn;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b1, 6'd8,  6'd8,  32'hA5,       32'h3C,       32'hA5,       32'h3C,       1'b0},
        '{1'b0,1'b1,1'b0,1'b0,1'b1, 6'd8,  6'd8,  32'h5A,       32'hC3,       32'h5A,       32'hC3,       1'b0},
        '{1'b1,1'b0,1'b1,1'b0,1'b1, 6'd8,  6'd8,  32'hC1,       32'h0F,       32'h83,       32'hF0,       1'b0},
        '{1'b1,1'b1,1'b0,1'b0,1'b1, 6'd12, 6'd12, 32'hABC,      32'h123,      32'hABC,      32'h123,      1'b0},
        '{1'b0,1'b0,1'b1,1'b0,1'b1, 6'd1,  6'd1,  32'h1,        32'h0,        32'h1,        32'h0,        1'b0},
        '{1'b1,1'b1,1'b0,1'b1,1'b1, 6'd16, 6'd16, 32'hBEEF,     32'h1234,     32'hBEEF,     32'h1234,     1'b0},
        '{1'b0,1'b1,1'b0,1'b0,1'b1, 6'd0,  6'd32, 32'hDEADBEEF, 32'h0F0F1234, 32'hDEADBEEF, 32'h0F0F1234, 1'b0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0, 6'd8,  6'd8,  32'hA5,       32'h5A,       32'hA5,       32'h5A,       1'b1},
        '{1'b1,1'b0,1'b1,1'b0,1'b1, 6'd4,  6'd4,  32'h1,        32'h6,        32'h8,        32'h6,        1'b0},
        '{1'b0,1'b0,1'b0,1'b0,1'b1, 6'd40, 6'd32, 32'h12345678, 32'h87654321, 32'h12345678, 32'h87654321, 1'b0},
        '{1'b0,1'b0,1'b0,1'b1,1'b0, 6'd8,  6'd8,  32'h81,       32'h7E,       32'h81,       32'h7E,       1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int w0, e0;
        // R11: reset state
        do_reset();
        check("R11 word_vld", word_vld, 0);
        check("R11 word_count", word_count, 0);
        check("R11 cs_evt", cs_evt, 0);
        check("R11 word_mosi", word_mosi, 0);
        check("R11 word_miso", word_miso, 0);

        // Table vectors: R1 R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            cpol = VECS[v].cpol; cpha = VECS[v].cpha; lsb = VECS[v].lsb;
            csh = VECS[v].csh; len = VECS[v].len;
            do_reset();
            w0 = n_words; e0 = n_evts;
            if (VECS[v].cs_on) begin
                cs = csh;
                repeat (H) @(negedge clk);
            end
            send_word(int'(VECS[v].nbits), VECS[v].tx_mo, VECS[v].tx_mi);
            check($sformatf("R1 R4 vec%0d word pulses", v), n_words - w0, 1);
            check($sformatf("R2 R3 vec%0d mosi", v), word_mosi, VECS[v].ex_mo);
            check($sformatf("R2 R3 vec%0d miso", v), word_miso, VECS[v].ex_mi);
            check($sformatf("R5 R7 vec%0d warn", v), word_warn, VECS[v].ex_warn);
            check($sformatf("R10 vec%0d count", v), word_count, 1);
            cs = ~csh;
            repeat (8) @(negedge clk);
            check($sformatf("R6 vec%0d events", v), n_evts - e0, VECS[v].cs_on ? 2 : 0);
        end

        // R12: latency of a word (mode 0, 1 bit)
        cpol = 0; cpha = 0; lsb = 0; csh = 0; len = 6'd1;
        do_reset();
        cs = 0; mosi = 1; miso = 0;
        repeat (8) @(negedge clk);
        sck = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R12 vld not before third edge", word_vld, 0);
        @(posedge clk); @(negedge clk);
        check("R12 vld at third edge", word_vld, 1);
        check("R12 mosi at third edge", word_mosi, 1);
        @(negedge clk);
        check("R9 vld one cycle", word_vld, 0);
        sck = 0;
        repeat (6) @(negedge clk);

        // R6: chip-select event with no clock activity, exact timing
        cs = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R6 evt not early", cs_evt, 0);
        @(posedge clk); @(negedge clk);
        check("R6 evt pulse", cs_evt, 1);
        check("R6 evt prev", cs_evt_prev, 0);
        check("R6 evt new", cs_evt_new, 1);
        @(negedge clk);
        check("R6 evt one cycle", cs_evt, 0);

        // R7 R8: warned word then clean word without reset
        cpol = 0; cpha = 0; lsb = 0; csh = 0; len = 6'd8;
        do_reset();
        send_word(8, 32'h96, 32'h69);
        check("R7 warned word data", word_mosi, 32'h96);
        check("R7 warn set", word_warn, 1);
        cs = 0;
        repeat (H) @(negedge clk);
        send_word(8, 32'h3C, 32'hC3);
        check("R8 second word data", word_mosi, 32'h3C);
        check("R8 warn cleared", word_warn, 0);
        check("R10 two words", word_count, 2);

        // R10: saturation at 3-bit maximum, reset clears
        len = 6'd1;
        do_reset();
        cs = 0;
        for (int k = 0; k < 9; k++) send_word(1, 32'h1, 32'h0);
        check("R10 saturated count", word_count, 7);
        do_reset();
        check("R10 cleared by reset", word_count, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule